// File: doc/BRIEF.md
# Line Test Pattern Generator

This block chooses the bit placed on the serial transmit output of a T1/E1 line path. Depending on a 2-bit pattern select, a clock-source bit and the line type, it forwards the user's transmit data, sends a constant level, or sends a maximal-length pseudo-random test sequence. The test sequence can be sent true or complemented.

In E1 mode the sequence comes from a 15-stage shift register. In T1/J1 mode it comes from a 20-stage register, and any zero run longer than a set limit is broken by a forced one, which makes the sequence quasi-random. Each bit is emitted on a clock-enable pulse. The clock-source bit picks which of two enables paces the output: the transmit-clock enable or the master-clock enable.

The output is registered. Shift-register lengths, tap positions and the zero-run limit are parameters. The bench therefore runs a reduced configuration whose full sequence periods fit in a short run.

Top module: `line_pattern_gen`

## Requirements
- R1: While reset is asserted and after its release, before the first step, `tx_data_out` is 0 and the generator holds its seed, which is all ones over the active length.
- R2: With `pat_sel` = 2'b01, every step drives `tx_data_out` to 1.
- R3: With `pat_sel` = 2'b00 and `clk_src` = 0, or with `pat_sel` = 2'b11 and either `clk_src`, each step copies `tx_data_in` to `tx_data_out`.
- R4: With `pat_sel` = 2'b00 and `clk_src` = 1, every step drives `tx_data_out` to 0.
- R5: A step is a clock edge on which the selected enable is high. That enable is `tx_clk_en` when `clk_src` = 0 and `mst_clk_en` when `clk_src` = 1. On any other edge `tx_data_out` keeps its value.
- R6: With `pat_sel` = 2'b10 and `t1_mode` = 0, the emitted sequence o obeys o[n+E1_LEN] = o[n] xor o[n+E1_LEN-E1_TAP], starting from E1_LEN ones. The sequence repeats with period 2^E1_LEN-1.
- R7: With `pat_sel` = 2'b10 and `t1_mode` = 1, the raw sequence obeys o[n+T1_LEN] = o[n] xor o[n+T1_LEN-T1_TAP], starting from T1_LEN ones. Its period is 2^T1_LEN-1.
- R8: In T1 mode, a raw zero that would make the emitted run of zeros longer than MAX_ZRUN is sent as a one, and the run count restarts. E1 output is never altered this way.
- R9: With `seq_inv` = 1, each test-sequence bit is sent complemented. Zero-run counting works on the bits before the complement.
- R10: The generator advances only on steps taken with `pat_sel` = 2'b10. After an interval in another mode, the sequence resumes at the next bit.
- R11: A change of `t1_mode` reseeds the generator for the new line type and clears the zero-run count, so the next sequence bits start from the seed.
- R12: The generator state is never all zeros. An all-zero state would be reseeded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_clk_en | input | 1 | Transmit-clock bit enable |
| mst_clk_en | input | 1 | Master-clock bit enable |
| pat_sel | input | 2 | Pattern select: 00 data/zeros, 01 ones, 10 test sequence, 11 data |
| clk_src | input | 1 | 0 paces with tx_clk_en, 1 with mst_clk_en; with pat_sel 00 it also selects zeros |
| seq_inv | input | 1 | Complement the test sequence |
| t1_mode | input | 1 | 0 for E1 sequence, 1 for T1/J1 quasi-random sequence |
| tx_data_in | input | 1 | User transmit data |
| tx_data_out | output | 1 | Registered serial output |

## Verification
The E1 sequence is compared bit by bit against a recurrence computed in the bench over two full periods. The enable pattern skips some edges and pulses the unselected enable, which shows whether steps are taken from the correct source. The T1 sequence runs through two periods, true in the first and complemented in the second, with zero-run forcing applied in the bench model; this separates the inversion from the zero-limit rule. A short burst of ones inside the E1 run shows whether the generator freezes or keeps running. Pass-through and constant patterns use alternating data with both clock sources, so that the reserved code and the zeros code can be told apart.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

  typedef enum logic [1:0] {
    PSEL_BASE = 2'b00,
    PSEL_ONES = 2'b01,
    PSEL_SEQ  = 2'b10,
    PSEL_RSVD = 2'b11
  } psel_e;

  typedef enum logic [1:0] {
    SRC_DATA,
    SRC_ONE,
    SRC_ZERO,
    SRC_SEQ
  } src_e;

  // Decode of pattern select plus clock-source bit into an output source.
  function automatic src_e decode_src(input logic [1:0] sel, input logic csrc);
    src_e r;
    case (sel)
      PSEL_ONES: r = SRC_ONE;
      PSEL_SEQ:  r = SRC_SEQ;
      PSEL_BASE: r = csrc ? SRC_ZERO : SRC_DATA;
      default:   r = SRC_DATA;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lpg_step_sel.sv
module lpg_step_sel (
  input  logic clk_src,
  input  logic tx_clk_en,
  input  logic mst_clk_en,
  output logic step
);
  assign step = clk_src ? mst_clk_en : tx_clk_en;
endmodule

// File: rtl/lpg_seq_gen.sv
module lpg_seq_gen #(
  parameter int E1_LEN   = 15,
  parameter int E1_TAP   = 14,
  parameter int T1_LEN   = 20,
  parameter int T1_TAP   = 17,
  parameter int MAX_ZRUN = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic t1_mode,
  input  logic advance,
  output logic seq_bit
);
  localparam int SR_W = (T1_LEN > E1_LEN) ? T1_LEN : E1_LEN;
  localparam int ZC_W = $clog2(MAX_ZRUN + 1);
  localparam logic [ZC_W-1:0] ZC_MAX = ZC_W'(MAX_ZRUN);

  logic [SR_W-1:0] state_q;
  logic [ZC_W-1:0] zrun_q;
  logic            t1_q;

  // Named internal events
  logic mode_flip;
  logic state_zero;
  logic raw_bit;
  logic force_one;

  function automatic logic [SR_W-1:0] seed_for(input logic t1);
    logic [SR_W-1:0] r;
    r = '0;
    for (int i = 0; i < SR_W; i++)
      if (i < (t1 ? T1_LEN : E1_LEN)) r[i] = 1'b1;
    return r;
  endfunction

  function automatic logic msb_of(input logic [SR_W-1:0] s, input logic t1);
    logic b;
    b = 1'b0;
    for (int i = 0; i < SR_W; i++)
      if (i == (t1 ? T1_LEN : E1_LEN) - 1) b = s[i];
    return b;
  endfunction

  // Fibonacci step: feedback of stage LEN and stage TAP enters at bit 0.
  function automatic logic [SR_W-1:0] lfsr_next(input logic [SR_W-1:0] s, input logic t1);
    logic [SR_W-1:0] r;
    logic fb;
    fb = 1'b0;
    for (int i = 0; i < SR_W; i++) begin
      if (i == (t1 ? T1_LEN : E1_LEN) - 1) fb = fb ^ s[i];
      if (i == (t1 ? T1_TAP : E1_TAP) - 1) fb = fb ^ s[i];
    end
    r = {s[SR_W-2:0], fb};
    for (int i = 0; i < SR_W; i++)
      if (i >= (t1 ? T1_LEN : E1_LEN)) r[i] = 1'b0;
    return r;
  endfunction

  assign mode_flip  = (t1_mode != t1_q);
  assign state_zero = (state_q == '0);
  assign raw_bit    = msb_of(state_q, t1_q);
  assign force_one  = t1_q && !raw_bit && (zrun_q == ZC_MAX);
  assign seq_bit    = raw_bit | force_one;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= seed_for(1'b0);
      zrun_q  <= '0;
      t1_q    <= 1'b0;
    end else begin
      t1_q <= t1_mode;
      if (mode_flip) begin
        state_q <= seed_for(t1_mode);
        zrun_q  <= '0;
      end else if (advance) begin
        state_q <= state_zero ? seed_for(t1_q) : lfsr_next(state_q, t1_q);
        if (!t1_q || seq_bit) zrun_q <= '0;
        else                  zrun_q <= zrun_q + 1'b1;
      end
    end
  end

  AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !state_zero); // R12
  AST_ZRUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    zrun_q <= ZC_MAX); // R8
  AST_GEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !mode_flip) |=> $stable(state_q)); // R10
  AST_RESEED_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    mode_flip |=> raw_bit); // R11

endmodule

// File: rtl/lpg_out_stage.sv
module lpg_out_stage
  import lpg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  src_e src,
  input  logic data_in,
  input  logic seq_bit,
  input  logic inv,
  output logic data_out
);
  logic next_bit;

  always_comb begin
    case (src)
      SRC_ONE:  next_bit = 1'b1;
      SRC_ZERO: next_bit = 1'b0;
      SRC_SEQ:  next_bit = seq_bit ^ inv;
      default:  next_bit = data_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    data_out <= 1'b0;
    else if (step) data_out <= next_bit;
  end

  AST_ONES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && src == SRC_ONE) |=> data_out); // R2
  AST_ZEROS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && src == SRC_ZERO) |=> !data_out); // R4
  AST_PASS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (step && src == SRC_DATA) |=> (data_out == $past(data_in))); // R3
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(data_out)); // R5

endmodule

// File: rtl/line_pattern_gen.sv
module line_pattern_gen
  import lpg_pkg::*;
#(
  parameter int E1_LEN   = 15,
  parameter int E1_TAP   = 14,
  parameter int T1_LEN   = 20,
  parameter int T1_TAP   = 17,
  parameter int MAX_ZRUN = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_clk_en,
  input  logic       mst_clk_en,
  input  logic [1:0] pat_sel,
  input  logic       clk_src,
  input  logic       seq_inv,
  input  logic       t1_mode,
  input  logic       tx_data_in,
  output logic       tx_data_out
);
  logic step;
  logic advance;
  logic seq_bit;
  src_e src;

  assign src     = decode_src(pat_sel, clk_src);
  assign advance = step && (src == SRC_SEQ);

  lpg_step_sel u_step (
    .clk_src    (clk_src),
    .tx_clk_en  (tx_clk_en),
    .mst_clk_en (mst_clk_en),
    .step       (step)
  );

  lpg_seq_gen #(
    .E1_LEN   (E1_LEN),
    .E1_TAP   (E1_TAP),
    .T1_LEN   (T1_LEN),
    .T1_TAP   (T1_TAP),
    .MAX_ZRUN (MAX_ZRUN)
  ) u_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .t1_mode (t1_mode),
    .advance (advance),
    .seq_bit (seq_bit)
  );

  lpg_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .src      (src),
    .data_in  (tx_data_in),
    .seq_bit  (seq_bit),
    .inv      (seq_inv),
    .data_out (tx_data_out)
  );

endmodule

// File: tb/line_pattern_gen_tb.sv
`timescale 1ns/1ps
module line_pattern_gen_tb;
  localparam int E1L = 5, E1T = 3, T1L = 7, T1T = 6, ZMAX = 3;
  localparam int E1P = (1 << E1L) - 1;
  localparam int T1P = (1 << T1L) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_clk_en = 1'b0, mst_clk_en = 1'b0;
  logic [1:0] pat_sel = 2'b00;
  logic clk_src = 1'b0, seq_inv = 1'b0, t1_mode = 1'b0, tx_data_in = 1'b0;
  logic tx_data_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic e1_ref [0:2*E1P-1];
  logic t1_raw [0:2*T1P-1];
  logic t1_exp [0:2*T1P-1];
  logic got    [0:2*E1P-1];

  always #2 clk = ~clk;

  line_pattern_gen #(.E1_LEN(E1L), .E1_TAP(E1T), .T1_LEN(T1L), .T1_TAP(T1T),
                     .MAX_ZRUN(ZMAX)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_clk_en(tx_clk_en), .mst_clk_en(mst_clk_en),
    .pat_sel(pat_sel), .clk_src(clk_src), .seq_inv(seq_inv), .t1_mode(t1_mode),
    .tx_data_in(tx_data_in), .tx_data_out(tx_data_out));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic tx, input logic mst);
    tx_clk_en = tx;
    mst_clk_en = mst;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    int zc;
    logic prev;
    // reference sequences from the recurrences
    for (int i = 0; i < 2*E1P; i++)
      e1_ref[i] = (i < E1L) ? 1'b1 : (e1_ref[i-E1L] ^ e1_ref[i-E1T]);
    for (int i = 0; i < 2*T1P; i++)
      t1_raw[i] = (i < T1L) ? 1'b1 : (t1_raw[i-T1L] ^ t1_raw[i-T1T]);
    zc = 0;
    for (int i = 0; i < 2*T1P; i++) begin
      if (!t1_raw[i] && zc == ZMAX) begin t1_exp[i] = 1'b1; zc = 0; end
      else if (!t1_raw[i]) begin t1_exp[i] = 1'b0; zc++; end
      else begin t1_exp[i] = 1'b1; zc = 0; end
    end

    // R1: reset
    repeat (3) tick(1'b1, 1'b1);
    chk("R1 out in reset", tx_data_out, 1'b0);
    rst_n = 1'b1;
    tick(1'b0, 1'b0);
    chk("R1 out after reset", tx_data_out, 1'b0);

    // E1 sequence, tx enable paced, with skipped and foreign pulses
    pat_sel = 2'b10; clk_src = 1'b0;
    n = 0;
    for (int k = 0; n < 2*E1P; k++) begin
      if (k % 3 == 2) begin
        prev = tx_data_out;
        tick(1'b0, 1'b1);
        chk("R5 mst pulse ignored", tx_data_out, prev);
      end else begin
        tick(1'b1, 1'b0);
        got[n] = tx_data_out;
        chk(n < E1L ? "R1 seed bits" : "R6 e1 bit", tx_data_out, e1_ref[n]);
        n++;
        if (n == 10) begin
          pat_sel = 2'b01;
          for (int j = 0; j < 3; j++) begin
            tick(1'b1, 1'b0);
            chk("R2 ones", tx_data_out, 1'b1);
          end
          pat_sel = 2'b10; // R10: resumes at bit 10
        end
      end
    end
    for (int i = 0; i < E1P; i++) chk("R6 period", got[i+E1P], got[i]);
    chk("R10 resume bit", got[10], e1_ref[10]);
    for (int i = 0; i + E1L <= 2*E1P; i++) begin
      int zs = 0;
      for (int j = 0; j < E1L; j++) zs += got[i+j] ? 0 : 1;
      chk("R12 no all-zero window", (zs == E1L), 1'b0);
    end

    // R11: switch to T1 without a step, then run on master enable
    pat_sel = 2'b00; clk_src = 1'b0; t1_mode = 1'b1;
    prev = tx_data_out;
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);
    chk("R5 no step hold", tx_data_out, prev);
    pat_sel = 2'b10; clk_src = 1'b1;
    n = 0;
    for (int k = 0; n < 2*T1P; k++) begin
      seq_inv = (n >= T1P);
      if (k % 4 == 3) begin
        prev = tx_data_out;
        tick(1'b1, 1'b0);
        chk("R5 tx pulse ignored", tx_data_out, prev);
      end else begin
        tick(1'b0, 1'b1);
        if (n < T1L)       chk("R11 reseed", tx_data_out, t1_exp[n]);
        else if (n >= T1P) chk("R9 inverted", tx_data_out, ~t1_exp[n]);
        else if (t1_exp[n] != t1_raw[n]) chk("R8 forced one", tx_data_out, 1'b1);
        else               chk("R7 t1 bit", tx_data_out, t1_exp[n]);
        n++;
      end
    end
    seq_inv = 1'b0;

    // R3: pass-through, code 00 with tx clock and code 11 with master
    pat_sel = 2'b00; clk_src = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tx_data_in = ((i * 5) % 3) == 1;
      tick(1'b1, 1'b0);
      chk("R3 pass 00", tx_data_out, tx_data_in);
    end
    pat_sel = 2'b11; clk_src = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tx_data_in = i[0];
      tick(1'b0, 1'b1);
      chk("R3 pass 11", tx_data_out, tx_data_in);
    end
    // R4: zeros
    pat_sel = 2'b00; clk_src = 1'b1; tx_data_in = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tick(1'b0, 1'b1);
      chk("R4 zeros", tx_data_out, 1'b0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule